// File: doc/BRIEF.md
# Three-Wire Serial Register Port Slave

This block is the display-controller end of a three-wire serial register port. A host drives a chip select, a serial clock and one shared data line. Each transaction addresses one register with a 6-bit address and then moves one 8-bit value. In a write the host keeps the line for all sixteen clocks. In a read the host sends a shorter command, lets the line float for one clock, and then the block drives the register value back. The bidirectional pad is modelled as separate input, output and output-enable signals.

The block samples the serial signals with its own system clock. Serial clock edges are found after a synchronizer, so the serial clock must be several system clocks long. Four registers are mapped:
- a loopback test register;
- a fixed identity byte made of a chip nibble and a version nibble;
- a resolution register;
- a control register with a power bit and an ownership bit.

The ownership bit decides whether the resolution and power outputs to the rest of the chip follow the strap pins or the register contents.

Top module: `spi3w_regport`

## Requirements
- R1: A write frame is 16 serial clocks, sampled on the rising edge, MSB first: 6 address bits, a direction bit of 0, one pad bit whose value is ignored, then 8 data bits. The addressed register takes the data after the 16th rising edge.
- R2: A read frame starts with 6 address bits and a direction bit of 1. During the 8th clock `sdo_oe` stays low. The 8 data bits then follow MSB first with `sdo_oe` high, each valid before the rising edge that samples it. `sdo_oe` returns low after the falling edge that follows the 16th rising edge.
- R3: Address 0x00 reads back the last value written to it. It resets to 0x00.
- R4: Address 0x01 reads {ID_NIB, VER_NIB}, which is 0x13 by default. Writes to it have no effect.
- R5: Address 0x02 reads the effective 3-bit resolution code in bits [2:0], with zeros above. A write stores bits [2:0] as the software code.
- R6: Address 0x03 keeps bit 0 (power: 1 = active, 0 = standby) and bit 7 (ownership: 1 = software). All other bits read 0. It resets to 0x00.
- R7: While ownership is 0, `res_code` equals `strap_res` and `pwr_on` equals `strap_pwr`. While it is 1, they equal the stored code and the stored power bit.
- R8: `sdo` changes only after a falling edge of `sclk`, never after a rising one.
- R9: If `cs_n` rises before a frame completes, no register changes, and `sdo_oe` is low within 3 system clocks.
- R10: After reset, `sdo_oe` is 0, all registers hold their reset values, and the first frame after reset release is accepted.
- R11: Reads of unmapped addresses return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial signals |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Data line as seen from the pad |
| sdo | output | 1 | Data driven onto the line during reads |
| sdo_oe | output | 1 | Output enable for the data pad |
| strap_res | input | 3 | Resolution code from strap pins |
| strap_pwr | input | 1 | Power state from strap pin (1 = active) |
| res_code | output | 3 | Effective resolution code |
| pwr_on | output | 1 | Effective power state (1 = active) |

## Verification
Two kinds of internal fault show at the ports, at different speeds.

A wrong bit count or a wrong latched direction shows up in the very next read. Data arrives one bit shifted, or `sdo_oe` rises during the turnaround clock or stays high after the frame.

A wrong register update shows in `res_code` and `pwr_on` within a few system clocks once ownership is set. It also shows in the next read of that register. The reference model checks those two outputs on every clock, so a bad control value is caught at once, not only at the next readback.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int RES_W     = 3;
  localparam int CMD_LEN   = ADDR_W + 2;
  localparam int FRAME_LEN = CMD_LEN + DATA_W;

  localparam logic [ADDR_W-1:0] ADR_LOOP  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_IDENT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_RES   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(3);

  localparam int CTRL_PM_BIT  = 0;
  localparam int CTRL_OWN_BIT = 7;

  // Control register image: only the power and ownership bits exist.
  function automatic logic [DATA_W-1:0] ctrl_word(input logic own, input logic pm);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_OWN_BIT] = own;
    w[CTRL_PM_BIT]  = pm;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] res_word(input logic [RES_W-1:0] r);
    return DATA_W'(r);
  endfunction

  function automatic logic [RES_W-1:0] pick_res(input logic own,
                                                input logic [RES_W-1:0] sw,
                                                input logic [RES_W-1:0] hw);
    return own ? sw : hw;
  endfunction
endpackage

// File: rtl/spi3w_insync.sv
module spi3w_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic cs_idle,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall
);
  // bit 2 = chip select, bit 1 = serial clock, bit 0 = data
  localparam logic [2:0] IDLE_VAL = 3'b100;

  logic [2:0] stage_q [STAGES];
  logic       sck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE_VAL;
      sck_prev_q <= 1'b0;
    end else begin
      stage_q[0] <= {cs_n_i, sclk_i, sdi_i};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      sck_prev_q <= stage_q[STAGES-1][1];
    end
  end

  assign cs_idle  = stage_q[STAGES-1][2];
  assign sdi_s    = stage_q[STAGES-1][0];
  assign sck_rise = stage_q[STAGES-1][1] & ~sck_prev_q;
  assign sck_fall = ~stage_q[STAGES-1][1] & sck_prev_q;
endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
  import spi3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              sdi_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_mode,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] DIR_POS   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] TURN_POS  = CNT_W'(CMD_LEN - 1);
  localparam logic [CNT_W-1:0] DRV_FIRST = CNT_W'(CMD_LEN);
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] DONE_POS  = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              sdo_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_idle) begin
      bit_cnt <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (sck_rise && bit_cnt != DONE_POS) begin
        bit_cnt <= bit_cnt + 1'b1;
        shift_q <= {shift_q[DATA_W-2:0], sdi_s};
        if (bit_cnt == DIR_POS) begin
          rd_q   <= sdi_s;
          addr_q <= shift_q[ADDR_W-1:0];
        end
        if (bit_cnt == TURN_POS && rd_q) tx_q <= rd_data;
      end
      if (sck_fall) begin
        if (rd_q && bit_cnt >= DRV_FIRST && bit_cnt < DONE_POS) begin
          oe_q  <= 1'b1;
          sdo_q <= tx_q[DATA_W-1];
          tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign reg_addr = addr_q;
  assign wr_stb   = sck_rise && !cs_idle && !rd_q && (bit_cnt == LAST_POS);
  assign wr_data  = {shift_q[DATA_W-2:0], sdi_s};
  assign rd_mode  = rd_q;
  assign sdo      = sdo_q;
  assign sdo_oe   = oe_q;
endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
  import spi3w_pkg::*;
#(
  parameter logic [3:0] ID_NIB  = 4'h1,
  parameter logic [3:0] VER_NIB = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RES_W-1:0]  strap_res,
  input  logic              strap_pwr,
  output logic [DATA_W-1:0] rd_data,
  output logic [RES_W-1:0]  res_code,
  output logic              pwr_on
);
  localparam logic [DATA_W-1:0] IDENT = DATA_W'({ID_NIB, VER_NIB});

  logic [DATA_W-1:0] loop_q;
  logic [RES_W-1:0]  res_sw_q;
  logic              pm_q;
  logic              own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q   <= '0;
      res_sw_q <= '0;
      pm_q     <= 1'b0;
      own_q    <= 1'b0;
    end else if (wr_stb) begin
      case (reg_addr)
        ADR_LOOP: loop_q   <= wr_data;
        ADR_RES:  res_sw_q <= wr_data[RES_W-1:0];
        ADR_CTRL: begin
          own_q <= wr_data[CTRL_OWN_BIT];
          pm_q  <= wr_data[CTRL_PM_BIT];
        end
        default: ;
      endcase
    end
  end

  assign res_code = pick_res(own_q, res_sw_q, strap_res);
  assign pwr_on   = own_q ? pm_q : strap_pwr;

  always_comb begin
    case (reg_addr)
      ADR_LOOP:  rd_data = loop_q;
      ADR_IDENT: rd_data = IDENT;
      ADR_RES:   rd_data = res_word(res_code);
      ADR_CTRL:  rd_data = ctrl_word(own_q, pm_q);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spi3w_regport.sv
module spi3w_regport
  import spi3w_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ID_NIB      = 4'h1,
  parameter logic [3:0] VER_NIB     = 4'h3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic [RES_W-1:0] strap_res,
  input  logic             strap_pwr,
  output logic [RES_W-1:0] res_code,
  output logic             pwr_on
);
  logic              cs_idle;
  logic              sdi_s;
  logic              sck_rise;
  logic              sck_fall;
  logic [ADDR_W-1:0] reg_addr;
  logic              wr_stb;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              rd_mode;

  spi3w_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .cs_idle(cs_idle), .sdi_s(sdi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  spi3w_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sdi_s(sdi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rd_data(rd_data),
    .reg_addr(reg_addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_mode(rd_mode), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  spi3w_regs #(.ID_NIB(ID_NIB), .VER_NIB(VER_NIB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .reg_addr(reg_addr),
    .wr_data(wr_data), .strap_res(strap_res), .strap_pwr(strap_pwr),
    .rd_data(rd_data), .res_code(res_code), .pwr_on(pwr_on)
  );
endmodule

// File: rtl/spi3w_regport_chk.sv
module spi3w_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_idle,
  input logic sck_fall,
  input logic sdo,
  input logic sdo_oe,
  input logic wr_stb,
  input logic rd_mode
);
  // R9
  abort_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !sdo_oe);

  // R8
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sdo));

  // R2
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> ($past(sck_fall) && $past(rd_mode)));

  // R2
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rd_mode);

  // R1
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sdo_oe);
endmodule

bind spi3w_regport spi3w_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_fall(sck_fall),
  .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .rd_mode(rd_mode)
);

// File: tb/spi3w_regport_test.sv
module spi3w_regport_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       sdi = 1'b0;
  logic [2:0] strap_res = 3'd7;
  logic       strap_pwr = 1'b0;
  wire        sdo, sdo_oe, pwr_on;
  wire  [2:0] res_code;

  int checks = 0;
  int fails  = 0;
  bit settle = 0;
  int m_loop, m_res, m_pm, m_own;

  always #(CLK_P/2) clk = ~clk;

  spi3w_regport uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .strap_res(strap_res), .strap_pwr(strap_pwr),
    .res_code(res_code), .pwr_on(pwr_on)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_loop = 0; m_res = 0; m_pm = 0; m_own = 0;
  endfunction

  function automatic int m_eff_res();
    return m_own ? m_res : int'(strap_res);
  endfunction

  function automatic int m_eff_pwr();
    return m_own ? m_pm : int'(strap_pwr);
  endfunction

  function automatic int m_read(input int a);
    case (a)
      0: return m_loop;
      1: return 8'h13;
      2: return m_eff_res();
      3: return m_own * 128 + m_pm;
      default: return 0;
    endcase
  endfunction

  function automatic void m_write(input int a, input int d);
    case (a)
      0: m_loop = d & 8'hFF;
      2: m_res = d & 7;
      3: begin m_own = (d >> 7) & 1; m_pm = d & 1; end
      default: ;
    endcase
  endfunction

  // R7: reference outputs compared on every clock between frames
  always @(posedge clk) begin
    #(CLK_P/4);
    if (settle && rst_n) begin
      check("R7 res_code", int'(res_code), m_eff_res());
      check("R7 pwr_on", int'(pwr_on), m_eff_pwr());
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit b);
    sclk = 1'b0; sdi = b; wait_n(HALF);
    sclk = 1'b1; wait_n(HALF);
  endtask

  task automatic write_reg(input int a, input int d, input bit pad = 1'b1);
    logic [15:0] bits;
    settle = 0;
    bits = {a[5:0], 1'b0, pad, d[7:0]};
    cs_n = 1'b0; wait_n(2);
    for (int i = 15; i >= 0; i--) pulse(bits[i]);
    sclk = 1'b0; wait_n(HALF);
    cs_n = 1'b1; wait_n(6);
    m_write(a, d);
    settle = 1;
  endtask

  task automatic read_reg(input int a, input string req);
    logic [6:0] cmd;
    logic [7:0] got;
    logic       v;
    settle = 0;
    cmd = {a[5:0], 1'b1};
    cs_n = 1'b0; wait_n(2);
    for (int i = 6; i >= 0; i--) pulse(cmd[i]);
    sclk = 1'b0; sdi = 1'b0; wait_n(HALF);
    check("R2 turnaround oe", int'(sdo_oe), 0);
    sclk = 1'b1; wait_n(HALF);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; wait_n(HALF);
      check("R2 data oe", int'(sdo_oe), 1);
      v = sdo;
      got = {got[6:0], v};
      sclk = 1'b1; wait_n(HALF - 1);
      check("R8 sdo held after rise", int'(sdo), int'(v));
      wait_n(1);
    end
    sclk = 1'b0; wait_n(HALF);
    check("R2 oe released", int'(sdo_oe), 0);
    cs_n = 1'b1; wait_n(4);
    check(req, int'(got), m_read(a));
    settle = 1;
  endtask

  task automatic do_reset();
    settle = 0;
    rst_n = 1'b0; wait_n(4);
    rst_n = 1'b1; m_reset(); wait_n(1);
    settle = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_reset();
    wait_n(5);
    rst_n = 1'b1; wait_n(1);
    settle = 1;
    // R10 reset state
    check("R10 oe after reset", int'(sdo_oe), 0);
    read_reg(0, "R10 R3 loop reset value");
    read_reg(3, "R10 R6 ctrl reset value");
    // R1 R3 writes with pad bit 1 and 0
    write_reg(0, 8'h55, 1'b1);
    read_reg(0, "R1 R3 loop 0x55");
    write_reg(0, 8'hA3, 1'b0);
    read_reg(0, "R1 R3 loop 0xA3");
    // R4 identity
    read_reg(1, "R4 ident");
    write_reg(1, 8'hFF);
    read_reg(1, "R4 ident after write");
    // R5 R7 hardware ownership
    settle = 0; strap_res = 3'd5; strap_pwr = 1'b1; wait_n(2); settle = 1;
    read_reg(2, "R5 res follows strap");
    write_reg(2, 8'hF6);
    read_reg(2, "R5 res still strap when own 0");
    // R6 R7 software ownership
    write_reg(3, 8'h81);
    read_reg(3, "R6 ctrl 0x81");
    read_reg(2, "R5 res stored when own 1");
    check("R7 res sw", int'(res_code), 6);
    settle = 0; strap_res = 3'd1; strap_pwr = 1'b0; wait_n(2); settle = 1;
    check("R7 pwr ignores strap", int'(pwr_on), 1);
    write_reg(3, 8'hFF);
    read_reg(3, "R6 unused bits zero");
    write_reg(3, 8'h80);
    check("R7 standby", int'(pwr_on), 0);
    // R11 unmapped
    write_reg(6'h2A, 8'h77);
    read_reg(6'h2A, "R11 unmapped reads zero");
    read_reg(0, "R11 loop untouched");
    // R9 aborted write
    settle = 0;
    cs_n = 1'b0; wait_n(2);
    begin
      logic [15:0] bits;
      bits = {6'd0, 1'b0, 1'b1, 8'hC3};
      for (int i = 15; i >= 4; i--) pulse(bits[i]);
    end
    sclk = 1'b0; wait_n(HALF);
    cs_n = 1'b1; wait_n(6);
    settle = 1;
    read_reg(0, "R9 abort leaves loop");
    // R9 aborted read mid-data
    settle = 0;
    cs_n = 1'b0; wait_n(2);
    begin
      logic [6:0] cmd;
      cmd = {6'd1, 1'b1};
      for (int i = 6; i >= 0; i--) pulse(cmd[i]);
    end
    for (int i = 0; i < 4; i++) pulse(1'b0);
    sclk = 1'b0; wait_n(HALF);
    check("R9 oe high mid read", int'(sdo_oe), 1);
    cs_n = 1'b1; wait_n(3);
    check("R9 oe low after abort", int'(sdo_oe), 0);
    wait_n(3);
    settle = 1;
    // R10 reset in software mode
    do_reset();
    check("R10 outputs back to strap", int'(res_code), 1);
    read_reg(3, "R10 ctrl cleared");
    write_reg(0, 8'h3C);
    read_reg(0, "R10 first frame after reset");
    settle = 0;
    wait_n(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule